// File: doc/BRIEF.md
# Glitch-Free Three-Source Clock Selector

This block drives the system clock from one of three free-running sources: a fast primary clock, a slow secondary clock and an internal oscillator clock. A 2-bit select input chooses the source. When the accepted choice changes, the block first turns off the current source in that source's own clock domain. It then turns on the new source in the new source's domain. The output never carries a runt pulse, and it stays low for a short, bounded gap while the handover runs.

A request for the secondary source is refused while the secondary oscillator enable input is low, and the current source stays selected. A select value that changes during a handover is held. It is acted on only once the new source is running. Three status flags report which source drives the system clock, and at most one of them is high at any time. All three flags are low when the internal source is selected but has not yet reported stable.

Top module: `clk_src_switch`

## Requirements
- R1: The select input chooses the source as follows: 00 picks the primary clock, 01 picks the secondary clock, and 10 or 11 pick the internal clock. Once a switch has settled, the system clock has the period of the chosen source.
- R2: While reset is asserted and after it is released, the accepted choice is the primary clock, so the system clock follows the primary clock without any prior selection.
- R3: While the secondary enable input is low, a select value of 01 is ignored and the current source keeps driving the system clock.
- R4: During a switch, the longest interval between rising edges of the system clock is at least two new-source periods and at most one old-source period plus four new-source periods.
- R5: No high phase of the system clock is shorter than half the period of the fastest source.
- R6: At most one status flag is high at any time. The secondary-running flag is high exactly when the secondary clock drives the system clock.
- R7: The internal-stable flag is high when the internal clock drives the system clock and the internal-stable input is high. While the internal clock drives with that input low, all three flags are low.
- R8: The primary-ready flag is high only while the primary clock drives the system clock and the start-up-timer-done input is high.
- R9: A select value that arrives while a switch is in progress does not change the accepted choice. Once the switch completes, it starts the next switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary clock source |
| clk_sec | input | 1 | Secondary low-frequency clock source |
| clk_int | input | 1 | Internal oscillator clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Source select: 00 primary, 01 secondary, 1x internal |
| sec_osc_en | input | 1 | Secondary oscillator enabled; gates acceptance of 01 |
| pri_timer_done | input | 1 | Primary start-up timers have expired |
| int_osc_stable | input | 1 | Internal oscillator has settled |
| sys_clk | output | 1 | Glitch-free system clock |
| flag_pri_ready | output | 1 | Primary drives sys_clk and is ready |
| flag_sec_run | output | 1 | Secondary drives sys_clk |
| flag_int_stable | output | 1 | Internal drives sys_clk and is stable |

## Verification
A new select value is taken on the next rising edge of the system clock. The old source then stops within about two of its own cycles, and the new source appears after three to four of its own cycles. Each scenario therefore waits two microseconds after a select change before it measures a period or samples a flag. That wait covers even the slowest source with margin. The gap bound and the minimum pulse width are not sampled at fixed points. Monitors time every edge of the system clock and record the longest interval and the shortest high phase, and each switch scenario compares the recorded figures with bounds computed from the two source periods. Flags change only on falling edges of the sources, so they are read at arbitrary points inside stable windows.

// File: rtl/clk_src_pkg.sv
package clk_src_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_PRI = 2'd0,
    SRC_SEC = 2'd1,
    SRC_INT = 2'd2
  } src_e;

  function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
    logic [NUM_SRC-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/clk_src_leg.sv
module clk_src_leg #(
  parameter int SYNC_STAGES = 2,
  parameter bit RESET_ON    = 1'b0
) (
  input  logic clk_in,
  input  logic rst_n,
  input  logic want,
  input  logic others_on,
  output logic en,
  output logic clk_gated
);
  localparam int LAST = SYNC_STAGES - 1;

  logic             req;
  logic [LAST:0]    sync_q;

  // ask to run only once every other leg has released the output
  assign req = want & ~others_on;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) sync_q <= {SYNC_STAGES{RESET_ON}};
    else        sync_q <= {sync_q[LAST-1:0], req};
  end

  // enable moves while the source is low, so the AND gate never cuts a pulse
  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) en <= RESET_ON;
    else        en <= sync_q[LAST];
  end

  assign clk_gated = clk_in & en;

  // R5
  leg_exclusive_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    en |-> !others_on);
endmodule

// File: rtl/clk_src_decode.sv
module clk_src_decode
  import clk_src_pkg::*;
(
  input  logic               sys_clk,
  input  logic               rst_n,
  input  logic [1:0]         src_sel,
  input  logic               sec_osc_en,
  input  logic [NUM_SRC-1:0] leg_en,
  output logic [NUM_SRC-1:0] target_oh
);
  logic [NUM_SRC-1:0] next_oh;
  logic               settled;

  always_comb begin
    if (src_sel[1])                    next_oh = src_onehot(SRC_INT);
    else if (!src_sel[0])              next_oh = src_onehot(SRC_PRI);
    else if (sec_osc_en)               next_oh = src_onehot(SRC_SEC);
    else                               next_oh = target_oh;
  end

  assign settled = (leg_en == target_oh);

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)       target_oh <= src_onehot(SRC_PRI);
    else if (settled) target_oh <= next_oh;
  end

  // R3
  sec_refused_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (src_sel == 2'b01 && !sec_osc_en) |=> $stable(target_oh));

  // R9
  hold_in_switch_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !settled |=> $stable(target_oh));
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import clk_src_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       sec_osc_en,
  input  logic       pri_timer_done,
  input  logic       int_osc_stable,
  output logic       sys_clk,
  output logic       flag_pri_ready,
  output logic       flag_sec_run,
  output logic       flag_int_stable
);
  logic [NUM_SRC-1:0] src_clk;
  logic [NUM_SRC-1:0] leg_en;
  logic [NUM_SRC-1:0] leg_clk;
  logic [NUM_SRC-1:0] others_on;
  logic [NUM_SRC-1:0] target_oh;

  assign src_clk = {clk_int, clk_sec, clk_pri};

  clk_src_decode u_decode (
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .sec_osc_en (sec_osc_en),
    .leg_en     (leg_en),
    .target_oh  (target_oh)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    assign others_on[i] = |(leg_en & ~(NUM_SRC'(1) << i));

    clk_src_leg #(
      .SYNC_STAGES (SYNC_STAGES),
      .RESET_ON    (i == int'(SRC_PRI))
    ) u_leg (
      .clk_in    (src_clk[i]),
      .rst_n     (rst_n),
      .want      (target_oh[i]),
      .others_on (others_on[i]),
      .en        (leg_en[i]),
      .clk_gated (leg_clk[i])
    );
  end

  assign sys_clk         = |leg_clk;
  assign flag_pri_ready  = leg_en[SRC_PRI] & pri_timer_done;
  assign flag_sec_run    = leg_en[SRC_SEC];
  assign flag_int_stable = leg_en[SRC_INT] & int_osc_stable;

  // R6
  flags_onehot_chk: assert property (@(posedge clk_pri) disable iff (!rst_n)
    $onehot0({flag_pri_ready, flag_sec_run, flag_int_stable}));
endmodule

// File: tb/clk_src_switch_bench.sv
`timescale 1ns/1ps
module clk_src_switch_bench;
  localparam real T_PRI = 20.0;
  localparam real T_SEC = 122.0;
  localparam real T_INT = 50.0;

  logic clk_pri = 1'b0, clk_sec = 1'b0, clk_int = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic sec_osc_en = 1'b0, pri_timer_done = 1'b0, int_osc_stable = 1'b1;
  logic sys_clk, flag_pri_ready, flag_sec_run, flag_int_stable;

  int errors = 0, checks = 0;
  realtime last_rise = 0.0, max_gap = 0.0, min_high = 1.0e9;
  int fast_seen = 0;

  always #(T_PRI/2) clk_pri = ~clk_pri;
  always #(T_SEC/2) clk_sec = ~clk_sec;
  always #(T_INT/2) clk_int = ~clk_int;

  clk_src_switch u_clk_src_switch (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .clk_int(clk_int), .rst_n(rst_n),
    .src_sel(src_sel), .sec_osc_en(sec_osc_en), .pri_timer_done(pri_timer_done),
    .int_osc_stable(int_osc_stable), .sys_clk(sys_clk),
    .flag_pri_ready(flag_pri_ready), .flag_sec_run(flag_sec_run),
    .flag_int_stable(flag_int_stable)
  );

  always @(posedge sys_clk) begin
    if (last_rise > 0.0) begin
      if ($realtime - last_rise > max_gap) max_gap = $realtime - last_rise;
      if ($realtime - last_rise < T_PRI + 0.5) fast_seen++;
    end
    last_rise = $realtime;
  end

  always @(negedge sys_clk)
    if (rst_n && last_rise > 0.0 && $realtime - last_rise < min_high)
      min_high = $realtime - last_rise;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic period_is(input string req, input real exp);
    realtime t0;
    @(posedge sys_clk); t0 = $realtime;
    @(posedge sys_clk);
    check(($realtime - t0 > exp - 0.5) && ($realtime - t0 < exp + 0.5),
          req, "sys_clk period", $realtime - t0, exp);
  endtask

  task automatic flags_are(input string req, input logic [2:0] exp);
    #3;
    check({flag_pri_ready, flag_sec_run, flag_int_stable} == exp, req,
          "flags {pri,sec,int}",
          real'({flag_pri_ready, flag_sec_run, flag_int_stable}), real'(exp));
  endtask

  task automatic switch_with_gap(input logic [1:0] s, input real t_old,
                                 input real t_new);
    max_gap = 0.0;
    src_sel = s;
    #2000;
    // R4
    check(max_gap >= 2.0 * t_new && max_gap <= t_old + 4.0 * t_new,
          "R4", "longest gap", max_gap, t_old + 4.0 * t_new);
  endtask

  task automatic t_reset_state;
    #13; rst_n = 1'b0; #100; rst_n = 1'b1; #200;
    period_is("R2", T_PRI);
    flags_are("R8", 3'b000);
    pri_timer_done = 1'b1;
    flags_are("R2", 3'b100);
  endtask

  task automatic t_to_internal;
    switch_with_gap(2'b10, T_PRI, T_INT);
    period_is("R1", T_INT);
    flags_are("R7", 3'b001);
    int_osc_stable = 1'b0;
    flags_are("R7", 3'b000);
    int_osc_stable = 1'b1;
    flags_are("R6", 3'b001);
  endtask

  task automatic t_refuse_secondary;
    sec_osc_en = 1'b0;
    src_sel = 2'b01;
    #2000;
    period_is("R3", T_INT);
    flags_are("R3", 3'b001);
  endtask

  task automatic t_to_secondary;
    max_gap = 0.0;
    sec_osc_en = 1'b1;
    #2000;
    check(max_gap >= 2.0 * T_SEC && max_gap <= T_INT + 4.0 * T_SEC,
          "R4", "longest gap", max_gap, T_INT + 4.0 * T_SEC);
    period_is("R1", T_SEC);
    flags_are("R6", 3'b010);
  endtask

  task automatic t_sel_eleven;
    src_sel = 2'b11;
    #2000;
    period_is("R1", T_INT);
    flags_are("R1", 3'b001);
  endtask

  task automatic t_hold_pending;
    fast_seen = 0;
    @(posedge sys_clk); #5;
    src_sel = 2'b00;
    @(posedge sys_clk); #30;
    src_sel = 2'b01;
    #3000;
    // R9: primary must have run before the queued secondary request
    check(fast_seen >= 2, "R9", "primary-period edges seen", real'(fast_seen), 2.0);
    period_is("R9", T_SEC);
    flags_are("R9", 3'b010);
  endtask

  task automatic t_pulse_width;
    // R5
    check(min_high >= T_PRI / 2.0 - 0.1, "R5", "shortest high phase",
          min_high, T_PRI / 2.0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_to_internal();
    t_refuse_secondary();
    t_to_secondary();
    t_sel_eleven();
    t_hold_pending();
    t_pulse_width();
    finish_run();
  end
endmodule